// File: doc/BRIEF.md
# Dual-Clock Serial Field Store

This block is a serial-access store for one video field or frame, with an 8-bit write port and an 8-bit read port. The two ports run on independent clocks that may differ in frequency. It behaves as a programmable delay line. Each port has its own address pointer, and a restart pulse on that port returns the pointer to location zero. The number of read-clock cycles between a write restart and the following read restart sets the delay. There are no full or empty indications. The system infers occupancy from when it issues the restarts.

Each port has an advance enable that gates pointer movement. Two further controls act only on data and leave the pointers running. A write-side accept control lets a word through or leaves the addressed location untouched, which allows selective overwrite such as an inset picture. A read-side show control drives the output bus or releases it. A release is modelled as the bus reading zero with the drive flag low.

The read domain also measures how long ago the last write restart happened. It raises an overlap flag when a read restart lands in the window where old and new field contents could be mixed.

Top module: `serial_field_store`

## Requirements
- R1: When `wr_advance` and `wr_accept` are both high on a `wr_clk` rising edge, `wr_data` is stored at the write pointer and the pointer steps by one. Later reads return the stored words in write order, with the same bit values.
- R2: A write restart sampled together with `wr_advance` high stores the incoming word (if accepted) at location 0. The next advancing write goes to location 1.
- R3: A read restart sampled together with `rd_advance` high places the word at location 0 on `rd_data` after that same `rd_clk` edge, with no extra cycle. The following advancing edges return locations 1, 2 and onward.
- R4: While `wr_advance` is low and no restart is sampled, `wr_clk` edges store nothing and the write pointer holds.
- R5: While `rd_advance` is low and no restart is sampled, `rd_data` holds its last word and the read pointer holds.
- R6: While `wr_accept` is low, an advancing write edge leaves the addressed location unchanged, but the write pointer still steps.
- R7: The drive state is sampled on each `rd_clk` edge. When `rd_show` was low there, `rd_driven` is low and `rd_data` reads 0. An advancing read edge still steps the read pointer.
- R8: Both pointers wrap from location DEPTH-1 to location 0 when no restart arrives.
- R9: On each read restart, `rd_overlap` is updated, and it holds between read restarts. It goes to 1 only if a write restart has been seen in the read domain and the read-clock count since then is greater than GAP_LO (71) and less than GAP_HI (600). Otherwise it goes to 0. The count is saturating and starts once the write restart event has crossed a synchroniser.
- R10: After reset, both pointers are at location 0, and `rd_data`, `rd_driven` and `rd_overlap` are 0.
- R11: A restart takes precedence over the advance enable. A restart with advance low sets the pointer to 0. On the write side it stores nothing. On the read side it leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset of the write domain |
| wr_restart | input | 1 | Return write pointer to location 0 |
| wr_advance | input | 1 | Gate for write pointer movement and storing |
| wr_accept | input | 1 | Data-only enable; low leaves the location unchanged |
| wr_data | input | 8 | Incoming word |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read domain |
| rd_restart | input | 1 | Return read pointer to location 0 |
| rd_advance | input | 1 | Gate for read pointer movement and output update |
| rd_show | input | 1 | Data-only output drive enable |
| rd_data | output | 8 | Outgoing word; 0 while not driven |
| rd_driven | output | 1 | High when the output bus is driven |
| rd_overlap | output | 1 | Read restart landed inside the unsafe window |

## Verification
The properties assume that each reset is held high across at least one edge of its own clock. They also assume that every control is stable around the edges of the clock that samples it. The bench meets this by driving each port only on the falling edge of its own clock. Nothing checks the outcome when both ports touch the same location in the same instant, because the clocks are unrelated. The stimulus never reads a location near the one being written. The synchroniser adds a few cycles of uncertainty to the overlap window, so the bench places read restarts far from both window edges.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int unsigned WORD_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  restart;
        logic  advance;
        logic  accept;
        word_t data;
    } wr_cmd_t;

    typedef struct packed {
        logic restart;
        logic advance;
        logic show;
    } rd_cmd_t;

    // Next location with wrap to zero after the last one.
    function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sfs_wr_port.sv
module sfs_wr_port
    import sfs_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_cmd_t       cmd,
    output logic          we,
    output logic [AW-1:0] waddr,
    output word_t         wdata,
    output logic [AW-1:0] ptr,
    output logic          restart_tgl
);
    localparam logic [AW-1:0] AFTER_ZERO = AW'(ptr_step(0, DEPTH));

    always_comb begin
        we    = cmd.advance && cmd.accept && !rst;
        waddr = cmd.restart ? '0 : ptr;
        wdata = cmd.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr         <= '0;
            restart_tgl <= 1'b0;
        end else if (cmd.restart) begin
            ptr         <= cmd.advance ? AFTER_ZERO : '0;
            restart_tgl <= ~restart_tgl;
        end else if (cmd.advance) begin
            ptr <= AW'(ptr_step(32'(ptr), DEPTH));
        end
    end
endmodule

// File: rtl/sfs_rd_port.sv
module sfs_rd_port
    import sfs_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  rd_cmd_t       cmd,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] ptr,
    output logic          drive
);
    localparam logic [AW-1:0] AFTER_ZERO = AW'(ptr_step(0, DEPTH));

    always_comb begin
        re    = cmd.advance;
        raddr = cmd.restart ? '0 : ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            drive <= 1'b0;
        end else begin
            drive <= cmd.show;
            if (cmd.restart)
                ptr <= cmd.advance ? AFTER_ZERO : '0;
            else if (cmd.advance)
                ptr <= AW'(ptr_step(32'(ptr), DEPTH));
        end
    end
endmodule

// File: rtl/sfs_store.sv
module sfs_store
    import sfs_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         q
);
    word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)
            q <= '0;
        else if (re)
            q <= mem[raddr];
    end
endmodule

// File: rtl/sfs_gap_mon.sv
module sfs_gap_mon #(
    parameter int unsigned GAP_LO = 71,
    parameter int unsigned GAP_HI = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_tgl,
    input  logic rd_restart,
    output logic overlap
);
    localparam int unsigned CW = $clog2(GAP_HI + 1);
    localparam logic [CW-1:0] LO_C = CW'(GAP_LO);
    localparam logic [CW-1:0] HI_C = CW'(GAP_HI);

    logic [2:0]    sync_q;
    logic          event_seen;
    logic          seen_q;
    logic [CW-1:0] count_q;

    assign event_seen = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], wr_tgl};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            count_q <= '0;
            overlap <= 1'b0;
        end else begin
            if (rd_restart)
                overlap <= seen_q && (count_q > LO_C) && (count_q < HI_C);
            if (event_seen) begin
                seen_q  <= 1'b1;
                count_q <= '0;
            end else if (seen_q && count_q != HI_C) begin
                count_q <= count_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_field_store.sv
module serial_field_store
    import sfs_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned GAP_LO = 71,
    parameter int unsigned GAP_HI = 600
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_restart,
    input  logic              wr_advance,
    input  logic              wr_accept,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_restart,
    input  logic              rd_advance,
    input  logic              rd_show,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_driven,
    output logic              rd_overlap
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    wr_cmd_t       wcmd;
    rd_cmd_t       rcmd;
    logic          we, re, wr_tgl;
    logic [AW-1:0] waddr, raddr, wr_ptr_q, rd_ptr_q;
    word_t         wdata, q;

    assign wcmd = '{restart: wr_restart, advance: wr_advance, accept: wr_accept, data: wr_data};
    assign rcmd = '{restart: rd_restart, advance: rd_advance, show: rd_show};

    sfs_wr_port #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .cmd(wcmd), .we(we), .waddr(waddr),
        .wdata(wdata), .ptr(wr_ptr_q), .restart_tgl(wr_tgl)
    );

    sfs_rd_port #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .cmd(rcmd), .re(re), .raddr(raddr),
        .ptr(rd_ptr_q), .drive(rd_driven)
    );

    sfs_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .re(re), .raddr(raddr), .q(q)
    );

    sfs_gap_mon #(.GAP_LO(GAP_LO), .GAP_HI(GAP_HI)) u_gap (
        .clk(rd_clk), .rst(rd_rst), .wr_tgl(wr_tgl),
        .rd_restart(rd_restart), .overlap(rd_overlap)
    );

    assign rd_data = rd_driven ? q : '0;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_restart,
    input logic          wr_advance,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_restart,
    input logic          rd_advance,
    input logic          rd_show,
    input logic [7:0]    rd_data,
    input logic          rd_driven,
    input logic          rd_overlap,
    input logic [AW-1:0] wr_ptr_q,
    input logic [AW-1:0] rd_ptr_q
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    p_wr_restart_go_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_restart && wr_advance |=> wr_ptr_q == AW'(1));

    p_wr_restart_idle_r11: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_restart && !wr_advance |=> wr_ptr_q == '0);

    p_wr_hold_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_restart && !wr_advance |=> $stable(wr_ptr_q));

    p_wr_step_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_restart && wr_advance |=>
        wr_ptr_q == (($past(wr_ptr_q) == LAST) ? '0 : $past(wr_ptr_q) + 1'b1));

    p_rd_restart_go_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_restart && rd_advance |=> rd_ptr_q == AW'(1));

    p_rd_hold_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_restart && !rd_advance && rd_show |=>
        $stable(rd_ptr_q) && (!$past(rd_driven) || $stable(rd_data)));

    p_rd_release_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_show |=> !rd_driven && rd_data == 8'h00);

    p_overlap_hold_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_restart |=> $stable(rd_overlap));
endmodule

bind serial_field_store sfs_checker #(.DEPTH(DEPTH), .AW(AW)) u_sfs_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_restart(wr_restart), .wr_advance(wr_advance),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_restart(rd_restart), .rd_advance(rd_advance),
    .rd_show(rd_show), .rd_data(rd_data), .rd_driven(rd_driven), .rd_overlap(rd_overlap),
    .wr_ptr_q(wr_ptr_q), .rd_ptr_q(rd_ptr_q)
);

// File: tb/tb_serial_field_store.sv
module tb_serial_field_store;
    localparam int TB_DEPTH = 1024;

    // {accept, data} per location, walked by one loop
    localparam logic [8:0] WVEC [16] = '{
        9'h1_A0, 9'h1_5F, 9'h0_EE, 9'h1_01, 9'h1_80, 9'h0_33, 9'h0_44, 9'h1_FF,
        9'h1_00, 9'h1_7E, 9'h0_C3, 9'h1_3C, 9'h1_96, 9'h0_11, 9'h1_69, 9'h1_E1
    };

    logic       wr_clk = 0, rd_clk = 0;
    logic       wr_rst = 1, rd_rst = 1;
    logic       wr_restart = 0, wr_advance = 0, wr_accept = 0;
    logic [7:0] wr_data = 0;
    logic       rd_restart = 0, rd_advance = 0, rd_show = 1;
    logic [7:0] rd_data;
    logic       rd_driven, rd_overlap;
    int         checks = 0, failures = 0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    serial_field_store #(.DEPTH(TB_DEPTH)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_restart(wr_restart),
        .wr_advance(wr_advance), .wr_accept(wr_accept), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_restart(rd_restart),
        .rd_advance(rd_advance), .rd_show(rd_show), .rd_data(rd_data),
        .rd_driven(rd_driven), .rd_overlap(rd_overlap)
    );

    function automatic logic [7:0] wrap_word(input int i);
        return 8'(i * 7 + 3);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic rs, input logic go, input logic acc, input logic [7:0] d);
        @(negedge wr_clk);
        wr_restart = rs; wr_advance = go; wr_accept = acc; wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_restart = 0; wr_advance = 0; wr_accept = 0;
    endtask

    task automatic rd_cyc(input logic rs, input logic go, input logic oe);
        @(negedge rd_clk);
        rd_restart = rs; rd_advance = go; rd_show = oe;
        @(posedge rd_clk);
        #1;
        rd_restart = 0; rd_advance = 0; rd_show = 1;
        #1;
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(posedge rd_clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] exp_mem [16];
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;
        #2;
        // R10: reset state at the ports
        chk("R10 rd_data", 32'(rd_data), 0);
        chk("R10 rd_driven", 32'(rd_driven), 0);
        chk("R10 rd_overlap", 32'(rd_overlap), 0);
        // R10: both pointers start at 0, with no restart used
        wr_cyc(0, 1, 1, 8'hA5);
        rd_cyc(0, 1, 1);
        chk("R10 pointers start at 0", 32'(rd_data), 32'h A5);

        // R1/R6: prefill, then table pass with some accepts low
        wr_cyc(1, 1, 1, 8'h10);
        for (int i = 1; i < 16; i++) wr_cyc(0, 1, 1, 8'(8'h10 + i));
        for (int i = 0; i < 16; i++) begin
            wr_cyc(i == 0, 1, WVEC[i][8], WVEC[i][7:0]);
            exp_mem[i] = WVEC[i][8] ? WVEC[i][7:0] : 8'(8'h10 + i);
        end
        for (int i = 0; i < 16; i++) begin
            rd_cyc(i == 0, 1, 1);
            if (i == 0) chk("R3 first word on restart edge", 32'(rd_data), 32'(exp_mem[0]));
            else if (WVEC[i][8]) chk("R1 word order", 32'(rd_data), 32'(exp_mem[i]));
            else chk("R6 masked location kept", 32'(rd_data), 32'(exp_mem[i]));
        end
        chk("R9 short gap no overlap", 32'(rd_overlap), 0);

        // R2/R4: restart stores at 0; idle edges store nothing
        wr_cyc(1, 1, 1, 8'h55);
        wr_cyc(0, 0, 1, 8'hEE);
        wr_cyc(0, 0, 1, 8'hEE);
        wr_cyc(0, 1, 1, 8'h66);
        rd_cyc(1, 1, 1);
        chk("R2 restart word at 0", 32'(rd_data), 32'h55);
        rd_cyc(0, 1, 1);
        chk("R4 no advance while idle", 32'(rd_data), 32'h66);

        // R5: read idle holds output and pointer
        rd_cyc(1, 1, 1);
        rd_cyc(0, 0, 1);
        chk("R5 output held", 32'(rd_data), 32'h55);
        rd_cyc(0, 0, 1);
        rd_cyc(0, 1, 1);
        chk("R5 pointer held", 32'(rd_data), 32'h66);

        // R7: released output, pointer still steps
        rd_cyc(1, 1, 0);
        chk("R7 data zero when released", 32'(rd_data), 0);
        chk("R7 drive flag low", 32'(rd_driven), 0);
        rd_cyc(0, 1, 1);
        chk("R7 pointer advanced while released", 32'(rd_data), 32'h66);

        // R11: restart with advance low
        wr_cyc(1, 0, 1, 8'h99);
        wr_cyc(0, 1, 1, 8'h77);
        rd_cyc(1, 0, 1);
        chk("R11 read output held on idle restart", 32'(rd_data), 32'h66);
        rd_cyc(0, 1, 1);
        chk("R11 write pointer zeroed, nothing stored", 32'(rd_data), 32'h77);

        // R8: wrap of both pointers
        wr_cyc(1, 1, 1, wrap_word(0));
        for (int i = 1; i <= TB_DEPTH + 1; i++) wr_cyc(0, 1, 1, wrap_word(i));
        for (int k = 0; k <= TB_DEPTH; k++) begin
            int loc;
            rd_cyc(k == 0, 1, 1);
            loc = k % TB_DEPTH;
            if (k < 3 || k >= TB_DEPTH - 1)
                chk("R8 wrap", 32'(rd_data),
                    32'((loc < 2) ? wrap_word(loc + TB_DEPTH) : wrap_word(loc)));
        end

        // R9: overlap window
        wr_cyc(1, 0, 0, 8'h00);
        rd_wait(300);
        rd_cyc(1, 0, 1);
        chk("R9 overlap inside window", 32'(rd_overlap), 1);
        rd_cyc(0, 0, 1);
        chk("R9 overlap held between restarts", 32'(rd_overlap), 1);
        rd_wait(900);
        rd_cyc(1, 0, 1);
        chk("R9 no overlap past upper bound", 32'(rd_overlap), 0);
        wr_cyc(1, 0, 0, 8'h00);
        rd_wait(20);
        rd_cyc(1, 0, 1);
        chk("R9 no overlap below lower bound", 32'(rd_overlap), 0);

        finish_run();
    end
endmodule